// File: doc/BRIEF.md
# Segmented Address Offset Translator

This block turns a system bus address into a memory controller address. Each request carries a path flag: cached or non-cached. Each path owns a group of eight segment registers. Each segment has a fixed address window, set by parameters. The block finds the window that holds the incoming address and reads the offset held in that segment. It treats the offset as a signed count of 16 MB units and adds it to the address. The result comes out one clock later, together with a valid flag.

Segments can be written through a simple port. A write carries a path, an index and a 32-bit word. Bits 14:0 of the word hold the offset and bit 31 is a lock flag. Once a segment is locked, it keeps its value until reset. A segment whose stored value is all zero is treated as unprogrammed. If a request hits an unprogrammed segment, or lands outside every window of its path, the block raises an error and drives no address. When windows overlap, the lowest matching index wins.

Top module: `seg_xlat_top`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, out_valid, out_err and out_addr are all zero. Reset clears every segment register, so any request made after reset reports an error.
- R2: If req_valid is high at an edge and the selected segment is programmed, out_valid is high after that edge. In the same cycle, out_addr equals req_addr plus the 15-bit offset sign-extended and multiplied by 2^24, taken modulo 2^38.
- R3: Window decode follows the path flag. With req_noncached=0 (cached path): index 0 covers 0x00_8000_0000–0x00_BFFF_FFFF and index 1 covers 0x10_0000_0000–0x13_FFFF_FFFF. With req_noncached=1 (non-cached path): index 2 covers 0x00_C000_0000–0x00_CFFF_FFFF, index 3 covers 0x14_0000_0000–0x17_FFFF_FFFF, index 4 covers 0x00_D000_0000–0x00_DFFF_FFFF and index 5 covers 0x18_0000_0000–0x1B_FFFF_FFFF. Every other index k in either group covers the single 16 MB unit starting at (0x100+k)·2^24.
- R4: A request that hits a segment whose stored value is zero gives out_err=1 and out_addr=0 after the edge.
- R5: A request whose address lies in no window of its path gives out_err=1 and out_addr=0 after the edge.
- R6: A write with wr_en=1 stores wr_data[14:0] as the offset and wr_data[31] as the lock flag. Bits 30:15 of wr_data are discarded. The new value first applies to requests presented in the cycle after the write; a request in the same cycle as the write still sees the old value.
- R7: After a segment's lock flag is set, later writes to that segment have no effect until reset. A locked segment whose offset is zero still counts as programmed and passes addresses through unchanged.
- R8: A write changes only the one segment named by wr_noncached and wr_idx. In particular, the same index in the other group is left unchanged.
- R9: If req_valid is low at an edge, then after that edge out_valid, out_err and out_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Segment write strobe |
| wr_noncached | input | 1 | Write group: 0 cached, 1 non-cached |
| wr_idx | input | 3 | Segment index to write |
| wr_data | input | 32 | Offset in [14:0], lock in [31] |
| req_valid | input | 1 | Translation request |
| req_noncached | input | 1 | Request path: 0 cached, 1 non-cached |
| req_addr | input | 38 | Incoming system address |
| out_valid | output | 1 | Registered result valid |
| out_err | output | 1 | Unprogrammed segment or no window |
| out_addr | output | 38 | Translated address, zero on error or idle |

## Verification
The bench uses the default parameters: a 38-bit address, eight segments per group and a 16 MB unit. With these values a 15-bit offset shifted by 24 is wider than the address, so the modulo wrap in R2 can be reached with one large positive offset. The default window map puts large and small windows in both groups. This makes it possible to probe window edges, reach unprogrammed indices, and check that the two groups stay apart under a single window table.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
    localparam int SEG_OFF_W    = 15;
    localparam int SEG_DATA_W   = 32;
    localparam int SEG_LOCK_BIT = 31;
    localparam int SEG_GROUPS   = 2;

    typedef struct packed {
        logic                 lock;
        logic [SEG_OFF_W-1:0] off;
    } seg_word_t;

    localparam int SEG_WORD_W = $bits(seg_word_t);
endpackage

// File: rtl/seg_regbank.sv
module seg_regbank
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 8,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [SEG_DATA_W-1:0]          wr_data,
    output seg_word_t [NUM_SEG-1:0]        words_o
);
    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^wr_data[SEG_LOCK_BIT-1:SEG_OFF_W];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        seg_word_t word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i)) && !word_q.lock) begin
                word_q.lock <= wr_data[SEG_LOCK_BIT];
                word_q.off  <= wr_data[SEG_OFF_W-1:0];
            end
        end
        assign words_o[i] = word_q;
    end
endmodule

// File: rtl/seg_window_decode.sv
module seg_window_decode #(
    parameter int ADDR_W    = 38,
    parameter int NUM_SEG   = 8,
    parameter int UNIT_LOG2 = 24,
    localparam int UNIT_W   = ADDR_W - UNIT_LOG2,
    localparam int IDX_W    = $clog2(NUM_SEG),
    parameter logic [NUM_SEG*UNIT_W-1:0] BASE = '0,
    parameter logic [NUM_SEG*UNIT_W-1:0] MASK = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [UNIT_W-1:0]  unit_addr;
    logic [NUM_SEG-1:0] match;

    assign unit_addr = addr_i[ADDR_W-1:UNIT_LOG2];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_win
        localparam logic [UNIT_W-1:0] WB = BASE[i*UNIT_W +: UNIT_W];
        localparam logic [UNIT_W-1:0] WM = MASK[i*UNIT_W +: UNIT_W];
        assign match[i] = ((unit_addr & ~WM) == (WB & ~WM));
    end

    // lowest matching index has priority
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SEG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
#(
    parameter int ADDR_W    = 38,
    parameter int NUM_SEG   = 8,
    parameter int UNIT_LOG2 = 24,
    localparam int UNIT_W   = ADDR_W - UNIT_LOG2,
    localparam int IDX_W    = $clog2(NUM_SEG),
    parameter logic [NUM_SEG*UNIT_W-1:0] C_BASE = {
        14'h0107, 14'h0106, 14'h0105, 14'h0104,
        14'h0103, 14'h0102, 14'h1000, 14'h0080},
    parameter logic [NUM_SEG*UNIT_W-1:0] C_MASK = {
        14'h0000, 14'h0000, 14'h0000, 14'h0000,
        14'h0000, 14'h0000, 14'h03FF, 14'h003F},
    parameter logic [NUM_SEG*UNIT_W-1:0] N_BASE = {
        14'h0107, 14'h0106, 14'h1800, 14'h00D0,
        14'h1400, 14'h00C0, 14'h0101, 14'h0100},
    parameter logic [NUM_SEG*UNIT_W-1:0] N_MASK = {
        14'h0000, 14'h0000, 14'h03FF, 14'h000F,
        14'h03FF, 14'h000F, 14'h0000, 14'h0000}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_noncached,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [SEG_DATA_W-1:0] wr_data,
    input  logic                  req_valid,
    input  logic                  req_noncached,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  out_valid,
    output logic                  out_err,
    output logic [ADDR_W-1:0]     out_addr
);
    localparam int WIDE_W = ADDR_W + SEG_OFF_W + UNIT_LOG2;

    seg_word_t [SEG_GROUPS-1:0][NUM_SEG-1:0] bank_words;
    logic      [SEG_GROUPS-1:0]              grp_hit;
    logic      [SEG_GROUPS-1:0][IDX_W-1:0]   grp_idx;

    for (genvar g = 0; g < SEG_GROUPS; g++) begin : g_grp
        seg_regbank #(
            .NUM_SEG (NUM_SEG)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_noncached == g[0])),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .words_o (bank_words[g])
        );

        seg_window_decode #(
            .ADDR_W    (ADDR_W),
            .NUM_SEG   (NUM_SEG),
            .UNIT_LOG2 (UNIT_LOG2),
            .BASE      ((g == 0) ? C_BASE : N_BASE),
            .MASK      ((g == 0) ? C_MASK : N_MASK)
        ) u_dec (
            .addr_i (req_addr),
            .hit_o  (grp_hit[g]),
            .idx_o  (grp_idx[g])
        );
    end

    seg_word_t                 sel_word;
    logic                      sel_hit;
    logic                      xl_err;
    logic signed [SEG_OFF_W-1:0] off_s;
    logic signed [WIDE_W-1:0]  delta_w;
    logic [ADDR_W-1:0]         xl_addr;

    always_comb begin
        sel_hit  = grp_hit[req_noncached];
        sel_word = bank_words[req_noncached][grp_idx[req_noncached]];
        xl_err   = !sel_hit || (sel_word == '0);
        off_s    = sel_word.off;
        delta_w  = WIDE_W'(off_s);
        delta_w  = delta_w <<< UNIT_LOG2;
        xl_addr  = req_addr + delta_w[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= req_valid;
            out_err   <= req_valid && xl_err;
            out_addr  <= (req_valid && !xl_err) ? xl_addr : '0;
        end
    end
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int ADDR_W  = 38,
    parameter int NUM_SEG = 8,
    parameter int GROUPS  = 2,
    parameter int WORD_W  = 16
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     req_valid,
    input logic                                     out_valid,
    input logic                                     out_err,
    input logic [ADDR_W-1:0]                        out_addr,
    input logic [GROUPS-1:0][NUM_SEG-1:0][WORD_W-1:0] words
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_err && out_addr == '0));

    p_err_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_addr == '0));

    p_err_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);

    for (genvar g = 0; g < GROUPS; g++) begin : g_g
        for (genvar i = 0; i < NUM_SEG; i++) begin : g_i
            p_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
                words[g][i][WORD_W-1] |=> $stable(words[g][i]));
        end
    end
endmodule

bind seg_xlat_top seg_xlat_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_SEG (NUM_SEG),
    .GROUPS  (seg_xlat_pkg::SEG_GROUPS),
    .WORD_W  (seg_xlat_pkg::SEG_WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_addr  (out_addr),
    .words     (bank_words)
);

// File: tb/seg_xlat_top_tb.sv
`timescale 1ns/1ps
module seg_xlat_top_tb_top;
    localparam int AW = 38;
    localparam longint U = 64'h100_0000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, wr_noncached, req_valid, req_noncached;
    logic [2:0]    wr_idx;
    logic [31:0]   wr_data;
    logic [AW-1:0] req_addr;
    logic          out_valid, out_err;
    logic [AW-1:0] out_addr;

    always #10 clk = ~clk;

    seg_xlat_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_noncached(wr_noncached),
        .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid),
        .req_noncached(req_noncached), .req_addr(req_addr),
        .out_valid(out_valid), .out_err(out_err), .out_addr(out_addr)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string tag = "R1";
    string e_tag;
    bit have_exp = 0;
    logic e_valid, e_err;
    logic [AW-1:0] e_addr;
    int m_off [2][8];
    bit m_lock[2][8];

    task automatic chk(string what, logic [AW-1:0] got, logic [AW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", e_tag, what, got, exp);
        end
    endtask

    function automatic int win_of(bit nc, longint a);
        if (!nc) begin
            if (a >= 64'h8000_0000 && a < 64'hC000_0000) return 0;
            if (a >= 64'h10_0000_0000 && a < 64'h14_0000_0000) return 1;
            for (int i = 2; i < 8; i++)
                if (a >= (256 + i) * U && a < (257 + i) * U) return i;
        end else begin
            if (a >= 64'hC000_0000 && a < 64'hD000_0000) return 2;
            if (a >= 64'hD000_0000 && a < 64'hE000_0000) return 4;
            if (a >= 64'h14_0000_0000 && a < 64'h18_0000_0000) return 3;
            if (a >= 64'h18_0000_0000 && a < 64'h1C_0000_0000) return 5;
            for (int i = 0; i < 8; i++)
                if ((i < 2 || i > 5) && a >= (256 + i) * U && a < (257 + i) * U) return i;
        end
        return -1;
    endfunction

    task automatic model_clear();
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < 8; i++) begin
                m_off[g][i] = 0;
                m_lock[g][i] = 0;
            end
    endtask

    task automatic compare();
        if (have_exp) begin
            chk("out_valid", AW'(out_valid), AW'(e_valid));
            chk("out_err", AW'(out_err), AW'(e_err));
            chk("out_addr", out_addr, e_addr);
        end
    endtask

    task automatic cyc(bit we, bit wnc, int widx, logic [31:0] wd,
                       bit rv, bit rnc, longint ra);
        int w;
        longint d, s;
        @(negedge clk);
        compare();
        wr_en = we; wr_noncached = wnc; wr_idx = 3'(widx); wr_data = wd;
        req_valid = rv; req_noncached = rnc; req_addr = AW'(ra);
        e_tag = tag;
        e_valid = rv; e_err = 1'b0; e_addr = '0;
        if (rv) begin
            w = win_of(rnc, ra);
            if (w < 0 || (m_off[rnc][w] == 0 && !m_lock[rnc][w])) begin
                e_err = 1'b1;
            end else begin
                d = (m_off[rnc][w] >= 16384) ? m_off[rnc][w] - 32768 : m_off[rnc][w];
                s = ra + d * U;
                e_addr = s[AW-1:0];
            end
        end
        have_exp = 1;
        if (we && !m_lock[wnc][widx]) begin
            m_off[wnc][widx]  = int'(wd[14:0]);
            m_lock[wnc][widx] = wd[31];
        end
    endtask

    task automatic wr(bit nc, int idx, logic [31:0] wd);
        cyc(1, nc, idx, wd, 0, 0, 0);
    endtask

    task automatic rq(bit nc, longint a);
        cyc(0, 0, 0, 32'h0, 1, nc, a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        have_exp = 0;
        rst_n = 1'b0;
        wr_en = 0; wr_noncached = 0; wr_idx = '0; wr_data = '0;
        req_valid = 1; req_noncached = 0; req_addr = AW'(64'h8000_0000);
        model_clear();
        repeat (2) @(negedge clk);
        e_tag = "R1";
        chk("reset out_valid", AW'(out_valid), '0);
        chk("reset out_err", AW'(out_err), '0);
        chk("reset out_addr", out_addr, '0);
        rst_n = 1'b1;
        req_valid = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1 got=timeout exp=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 0; wr_noncached = 0; wr_idx = '0; wr_data = '0;
        req_valid = 0; req_noncached = 0; req_addr = '0;
        model_clear();
        do_reset();
        // R1: registers clear after reset, any request errors
        tag = "R1";
        rq(0, 64'h8000_0000);
        rq(1, 64'h14_0000_0000);

        // R6: program the default map
        tag = "R6";
        wr(0, 0, 32'h0000_7F80);
        wr(0, 1, 32'h0000_7000);
        wr(1, 2, 32'h0000_7F40);
        wr(1, 3, 32'h0000_6C00);
        wr(1, 4, 32'h0000_7F30);
        wr(1, 5, 32'h0000_6800);

        // R3: window decode per path
        tag = "R3";
        rq(0, 64'h8000_0000);
        rq(0, 64'hBFFF_FFFF);
        rq(0, 64'h10_0000_0000);
        rq(0, 64'h13_FFFF_FFF0);
        rq(1, 64'hC000_1234);
        rq(1, 64'hD000_0040);
        rq(1, 64'h14_0000_0100);
        rq(1, 64'h18_0000_0008);
        rq(1, 64'h1B_FFFF_FFFF);

        // R5: addresses outside every window of their path
        tag = "R5";
        rq(0, 64'hC000_0000);
        rq(0, 64'h0);
        rq(1, 64'h8000_0000);
        rq(1, 64'h3F_FFFF_FFFF);

        // R4: unprogrammed segments
        tag = "R4";
        rq(1, (256 + 0) * U);
        rq(0, (256 + 4) * U + 5);
        rq(1, (256 + 7) * U);

        // R2: positive offset and modulo wrap
        tag = "R2";
        wr(0, 6, 32'h0000_0010);
        rq(0, (256 + 6) * U + 64'h77);
        wr(0, 7, 32'h0000_3FFF);
        rq(0, (256 + 7) * U + 64'h1);

        // R9: idle cycles keep outputs at zero
        tag = "R9";
        cyc(0, 0, 0, 32'h0, 0, 0, 64'h8000_0000);
        cyc(0, 0, 0, 32'h0, 0, 1, 64'hC000_0000);

        // R6: reserved bits discarded, write timing
        tag = "R6";
        wr(0, 2, 32'h7FFF_0005);
        rq(0, (256 + 2) * U + 64'h10);
        wr(0, 3, 32'h4000_0000);
        rq(0, (256 + 3) * U);
        cyc(1, 0, 2, 32'h0000_0009, 1, 0, (256 + 2) * U);
        rq(0, (256 + 2) * U);

        // R7: lock holds value, locked zero offset passes through
        tag = "R7";
        wr(1, 6, 32'h8000_0020);
        wr(1, 6, 32'h0000_0100);
        rq(1, (256 + 6) * U + 64'h3);
        wr(1, 6, 32'h0000_0000);
        rq(1, (256 + 6) * U);
        wr(0, 5, 32'h8000_0000);
        rq(0, (256 + 5) * U + 64'hABC);
        wr(0, 5, 32'h0000_0001);
        rq(0, (256 + 5) * U + 64'hABC);

        // R8: groups are independent
        tag = "R8";
        wr(0, 4, 32'h0000_0002);
        rq(1, 64'hD000_0080);
        rq(0, (256 + 4) * U + 64'h4);
        wr(1, 0, 32'h0000_0001);
        rq(0, 64'h8000_0100);
        rq(1, (256 + 0) * U);

        // R1: reset mid-run clears locks and offsets
        do_reset();
        tag = "R1";
        rq(1, (256 + 6) * U);
        rq(0, 64'h8000_0000);
        cyc(0, 0, 0, 32'h0, 0, 0, 0);
        @(negedge clk);
        compare();

        finished = 1;
        summary();
        $finish;
    end
endmodule